// File: doc/BRIEF.md
# Two-Tone Audio Bit Demodulator with Bit-Clock Recovery

This block turns a stream of signed 8-bit audio samples carrying 1200 baud two-tone (1200 Hz / 2200 Hz) signalling into a serial data-bit stream. Samples arrive at 9600 per second, which is eight samples per bit. Each sample is paced by a one-cycle valid strobe.

Tone detection multiplies every sample by the sample taken half a bit earlier. A first-order shift-and-add low-pass filter smooths that product, and a sign slicer turns it into a line level. A phase counter runs once per bit period and sets the instant at which the level is sampled. Each level transition nudges the counter toward the middle of the bit. Sampled levels are NRZI-decoded: a repeated level gives a 1 and a changed level gives a 0. Each recovered bit appears with a one-cycle strobe.

Top module: `afskDemod`

## Requirements
- R1: After reset, bitValid is 0 and bitOut is 0, and no bit is produced until samples arrive.
- R2: Only cycles with sampleValid high advance the block. sampleIn is ignored in all other cycles, so the bit timing counts only valid samples.
- R3: The discriminator multiplies each sample by the sample four valid samples earlier, using a delay line that is zero after reset. The signed product is shifted right arithmetically by 2 to form the filter input.
- R4: The filter computes y_new = x_prev + x_new + (y_old>>>1) + (y_old>>>3) + (y_old>>>5) in signed 16-bit. The line level is 1 when y_new > 0 and 0 otherwise. A steady 1200 Hz tone therefore gives level 0, and a steady 2200 Hz tone gives level 1.
- R5: The phase counter starts at 0 and gains 8 on each valid sample. It wraps at 64. With no level transitions, a bit is produced on exactly every 8th valid sample, the first one on the 8th sample after reset.
- R6: On a valid sample whose level differs from the previous level, the counter is first moved by 1: up if it is below 32, down otherwise. The per-sample advance is applied after that.
- R7: On a wrap, the current level is stored. bitOut becomes 1 if that level equals the previously stored level and 0 if it differs. bitValid is high for exactly one cycle, the cycle after the wrapping sample, and bitOut holds its value until the next strobe.
- R8: A steady single tone, after the first four bits, yields only 1 bits.
- R9: A phase-continuous two-tone NRZI stream (tone kept for data 1, switched for data 0) with peak amplitude from 40 to 120 is recovered without error after 80 bits. Recovery is at a fixed bit latency, and the stream yields one bit per eight samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | High for one cycle per new audio sample |
| sampleIn | input | 8 | Signed audio sample |
| bitOut | output | 1 | Last recovered data bit |
| bitValid | output | 1 | One-cycle strobe marking a new bitOut |

## Verification
A run of silent samples, with junk on sampleIn between strobes, isolates the free-running bit timer and the NRZI output for an unchanging level. Steady 1200 Hz and 2200 Hz tones separate the two slicer polarities of the discriminator and filter. Full NRZI streams at two amplitudes, each with an alternating preamble and a long run of ones, exercise the transition-driven clock recovery: the ones run shows the timing holding without edges, and the amplitude change shows the decision does not depend on signal level. The recovered bits are matched to the sent data at a single bit lag.

// File: rtl/afskDemodPkg.sv
package afskDemodPkg;
  typedef struct packed {
    logic shiftEn;
  } ctrlStrobe_t;

  typedef struct packed {
    logic newLevel;
    logic prevLevel;
  } levelPair_t;
endpackage

// File: rtl/afskDatapath.sv
module afskDatapath
  import afskDemodPkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int HALF_BIT   = 4,
  parameter int FILT_W     = 16,
  parameter int PROD_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output levelPair_t          levels
);
  localparam int PROD_W = 2 * SAMPLE_W;

  logic signed [SAMPLE_W-1:0] delayLine [HALF_BIT];
  logic signed [SAMPLE_W-1:0] sampleS;
  logic signed [PROD_W-1:0]   prod;
  logic signed [FILT_W-1:0]   xNew, xPrev, yOld, yNew;
  logic                       levelReg;

  assign sampleS = signed'(sampleIn);

  // Delay line of half a bit, oldest entry at the end
  for (genvar stg = 0; stg < HALF_BIT; stg++) begin : gDelay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        delayLine[stg] <= '0;
      end else if (strobe.shiftEn) begin
        if (stg == 0) delayLine[stg] <= sampleS;
        else          delayLine[stg] <= delayLine[stg-1];
      end
    end
  end

  assign prod = sampleS * delayLine[HALF_BIT-1];
  assign xNew = FILT_W'(prod >>> PROD_SHIFT);
  assign yNew = xPrev + xNew + (yOld >>> 1) + (yOld >>> 3) + (yOld >>> 5);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPrev    <= '0;
      yOld     <= '0;
      levelReg <= 1'b0;
    end else if (strobe.shiftEn) begin
      xPrev    <= xNew;
      yOld     <= yNew;
      levelReg <= (yNew > 0);
    end
  end

  assign levels.newLevel  = (yNew > 0);
  assign levels.prevLevel = levelReg;
endmodule

// File: rtl/afskControl.sv
module afskControl
  import afskDemodPkg::*;
#(
  parameter int SAMPLES_PER_BIT = 8,
  parameter int PHASE_INC       = 8,
  parameter int PHASE_STEP      = 1,
  parameter int PHASE_W         = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  levelPair_t                levels,
  output ctrlStrobe_t               strobe,
  output logic signed [PHASE_W-1:0] phaseNow,
  output logic                      bitOut,
  output logic                      bitValid
);
  localparam int PHASE_WRAP  = SAMPLES_PER_BIT * PHASE_INC;
  localparam int PHASE_THRES = PHASE_WRAP / 2;
  localparam logic signed [PHASE_W-1:0] WRAP_V  = PHASE_W'(PHASE_WRAP);
  localparam logic signed [PHASE_W-1:0] THRES_V = PHASE_W'(PHASE_THRES);
  localparam logic signed [PHASE_W-1:0] STEP_V  = PHASE_W'(PHASE_STEP);
  localparam logic signed [PHASE_W-1:0] INC_V   = PHASE_W'(PHASE_INC);

  logic signed [PHASE_W-1:0] phase, adj, advanced, nextPhase;
  logic levelEdge, wrap, foundLast;

  assign strobe.shiftEn = sampleValid;
  assign levelEdge = levels.newLevel ^ levels.prevLevel;

  always_comb begin
    if (!levelEdge)          adj = '0;
    else if (phase < THRES_V) adj = STEP_V;
    else                     adj = -STEP_V;
    advanced  = phase + adj + INC_V;
    wrap      = (advanced >= WRAP_V);
    nextPhase = wrap ? (advanced - WRAP_V) : advanced;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      foundLast <= 1'b0;
      bitOut    <= 1'b0;
      bitValid  <= 1'b0;
    end else begin
      bitValid <= sampleValid && wrap;
      if (sampleValid) begin
        phase <= nextPhase;
        if (wrap) begin
          foundLast <= levels.newLevel;
          bitOut    <= (levels.newLevel == foundLast);
        end
      end
    end
  end

  assign phaseNow = phase;
endmodule

// File: rtl/afskDemod.sv
module afskDemod
  import afskDemodPkg::*;
#(
  parameter int SAMPLE_W        = 8,
  parameter int SAMPLES_PER_BIT = 8,
  parameter int PHASE_INC       = 8,
  parameter int PHASE_STEP      = 1,
  parameter int FILT_W          = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                bitOut,
  output logic                bitValid
);
  localparam int HALF_BIT   = SAMPLES_PER_BIT / 2;
  localparam int PHASE_WRAP = SAMPLES_PER_BIT * PHASE_INC;
  localparam int PHASE_W    = $clog2(PHASE_WRAP + PHASE_INC + PHASE_STEP) + 1;

  ctrlStrobe_t               strobe;
  levelPair_t                levels;
  logic signed [PHASE_W-1:0] phaseNow;

  afskDatapath #(
    .SAMPLE_W(SAMPLE_W), .HALF_BIT(HALF_BIT), .FILT_W(FILT_W), .PROD_SHIFT(2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn), .levels(levels)
  );

  afskControl #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT), .PHASE_INC(PHASE_INC),
    .PHASE_STEP(PHASE_STEP), .PHASE_W(PHASE_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .levels(levels),
    .strobe(strobe), .phaseNow(phaseNow), .bitOut(bitOut), .bitValid(bitValid)
  );
endmodule

// File: rtl/afskDemodChk.sv
module afskDemodChk #(
  parameter int PHASE_W    = 8,
  parameter int PHASE_WRAP = 64
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      sampleValid,
  input logic                      bitValid,
  input logic                      bitOut,
  input logic signed [PHASE_W-1:0] phaseNow
);
  logic [4:0] sinceBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         sinceBit <= '0;
    else if (bitValid) sinceBit <= sampleValid ? 5'd1 : 5'd0;
    else if (sampleValid) sinceBit <= sinceBit + 5'd1;
  end

  // R7
  strobe_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(sampleValid));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R7
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> $stable(bitOut));

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseNow >= 0) && (phaseNow < PHASE_W'(PHASE_WRAP)));

  // R6
  bit_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (sinceBit >= 5'd7 && sinceBit <= 5'd10));
endmodule

bind afskDemod afskDemodChk #(.PHASE_W(PHASE_W), .PHASE_WRAP(PHASE_WRAP)) chk_i (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .bitValid(bitValid), .bitOut(bitOut), .phaseNow(phaseNow)
);

// File: tb/afskDemod_tb_top.sv
`timescale 1ns/1ps
module afskDemod_tb_top;
  localparam real PI = 3.14159265358979;
  localparam int MAXB = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [7:0] sampleIn = '0;
  logic bitOut, bitValid;

  int checks = 0, fails = 0;
  int samplesSent = 0;
  int rxCount = 0;
  bit finished = 1'b0;
  bit rxBits [MAXB];
  int rxIdx  [MAXB];
  bit txBits [MAXB];
  real tonePhase = 0.0;

  always #2 clk = ~clk;

  afskDemod dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .bitOut(bitOut), .bitValid(bitValid)
  );

  always @(negedge clk) begin
    if (rstN && bitValid && rxCount < MAXB) begin
      rxBits[rxCount] = bitOut;
      rxIdx[rxCount]  = samplesSent;
      rxCount++;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rxCount = 0;
    samplesSent = 0;
    tonePhase = 0.0;
  endtask

  // one valid sample, then three idle cycles carrying junk on sampleIn
  task automatic sendSample(input int s);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = 8'(s);
    samplesSent++;
    @(negedge clk);
    sampleValid = 1'b0;
    sampleIn = 8'($urandom);
    repeat (2) @(negedge clk);
  endtask

  function automatic int toneSample(input real ph, input int amp);
    return $rtoi($floor(amp * $sin(ph) + 0.5));
  endfunction

  task automatic sendToneBit(input bit mark, input int amp);
    real f;
    f = mark ? 1200.0 : 2200.0;
    for (int k = 0; k < 8; k++) begin
      tonePhase = tonePhase + 2.0 * PI * f / 9600.0;
      sendSample(toneSample(tonePhase, amp));
    end
  endtask

  function automatic int countMismatch(input int lag, input int first, input int last);
    int m = 0;
    for (int i = first; i <= last; i++)
      if (i + lag >= rxCount || rxBits[i+lag] != txBits[i]) m++;
    return m;
  endfunction

  task automatic runStream(input int amp, input int nbits, input string tag);
    bit mark;
    int best, bestLag, m;
    mark = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      if (i < 48) txBits[i] = 1'b0;
      else if (i >= 120 && i < 140) txBits[i] = 1'b1;
      else txBits[i] = 1'($urandom & 1);
      if (!txBits[i]) mark = ~mark;
      sendToneBit(mark, amp);
    end
    repeat (4) @(negedge clk);
    best = 1 << 30; bestLag = 0;
    for (int lag = 0; lag < 4; lag++) begin
      m = countMismatch(lag, 80, nbits - 8);
      if (m < best) begin best = m; bestLag = lag; end
    end
    // R9 error-free recovery after lock
    check({"R9 errors ", tag}, best == 0, best, 0);
    // R9 one bit per eight samples
    check({"R9 bit count ", tag}, rxCount >= nbits - 2 && rxCount <= nbits + 1, rxCount, nbits);
  endtask

  initial begin
    int ones;
    void'($urandom(32'd1357));
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 bitValid in reset", bitValid == 1'b0, int'(bitValid), 0);
    check("R1 bitOut in reset", bitOut == 1'b0, int'(bitOut), 0);
    doReset();
    repeat (5) @(negedge clk);
    check("R1 no bit without samples", rxCount == 0, rxCount, 0);

    // R5 R2 R7: silence, junk between strobes
    for (int i = 0; i < 24; i++) sendSample(0);
    check("R5 bits from 24 silent samples", rxCount == 3, rxCount, 3);
    check("R5 first bit on 8th sample", rxIdx[0] == 8, rxIdx[0], 8);
    check("R2 second bit on 16th sample", rxIdx[1] == 16, rxIdx[1], 16);
    check("R5 third bit on 24th sample", rxIdx[2] == 24, rxIdx[2], 24);
    ones = 0;
    for (int i = 0; i < 3; i++) ones += int'(rxBits[i]);
    check("R7 repeated level gives ones", ones == 3, ones, 3);

    // R8 R3 R4: steady mark tone
    doReset();
    for (int b = 0; b < 30; b++) sendToneBit(1'b1, 100);
    ones = 0;
    for (int i = 4; i < rxCount; i++) ones += int'(rxBits[i]);
    check("R8 mark tone ones", ones == rxCount - 4 && rxCount >= 28, ones, rxCount - 4);

    // R8 R3 R4: steady space tone
    doReset();
    for (int b = 0; b < 30; b++) sendToneBit(1'b0, 100);
    ones = 0;
    for (int i = 4; i < rxCount; i++) ones += int'(rxBits[i]);
    check("R8 space tone ones", ones == rxCount - 4 && rxCount >= 28, ones, rxCount - 4);

    // R9 R6: full streams
    doReset();
    runStream(120, 200, "amp120");
    doReset();
    runStream(40, 200, "amp40");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule